// File: doc/BRIEF.md
# Per-Chip-Select Programmable Wait Generator

This block belongs to an external bus controller. It lengthens each external bus cycle by a number of data wait clocks, and that number is set separately for each chip-select space. Two halfword control registers hold the settings. Each register packs four 3-bit wait codes, so the pair covers eight spaces. A plain write/read port programs the registers and reads them back.

Each bus cycle opens with a one-clock start strobe. The strobe carries the chip-select index and an area type. For an external cycle, the block raises a wait flag for as many clocks as the selected code asks for. It then pulses ready in the clock that completes the data phase. Internal ROM and RAM cycles get no programmed wait and finish in the start clock. Peripheral cycles ignore the codes and take their completion from the peripheral's own ready input. A parameter sets how many wait codes are actually implemented.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset, both control registers read 0x3333, and every chip-select space inserts 3 waits.
- R2: Register select 0 holds the codes of spaces 0..3 at bits [2:0], [6:4], [10:8] and [14:12]. Register select 1 holds spaces 4..7 at the same positions. A read returns the register chosen by `reg_sel` in the same clock.
- R3: Bits 3, 7, 11 and 15 of both registers always read zero. Data written to those bits is discarded.
- R4: An external cycle (area code 00) whose code is N raises `bus_wait` for N clocks, starting with the start clock. `bus_rdy` then pulses in the following clock. With N = 0, `bus_rdy` is high in the start clock itself. N never exceeds 7.
- R5: An internal ROM cycle (area code 01) or internal RAM cycle (area code 10) completes with `bus_rdy` high in the start clock and no wait, whatever the code.
- R6: In a peripheral cycle (area code 11), `bus_rdy` follows `periph_rdy` in every clock of the cycle, and the wait codes have no effect.
- R7: The wait count is captured at the start clock. A register write issued during a cycle does not change the length of that cycle, but it does apply to later cycles.
- R8: Codes for spaces at or above the implemented count read as zero, and those spaces behave as zero-wait.
- R9: Outside a bus cycle, both `bus_rdy` and `bus_wait` are low.
- R10: A write replaces the whole selected register at the next clock edge. The other register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register select, used for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| cyc_start | input | 1 | One-clock strobe that opens a bus cycle |
| cyc_area | input | 2 | Area type: 00 external, 01 internal ROM, 10 internal RAM, 11 peripheral |
| cyc_cs | input | CS_W | Chip-select index of the cycle |
| periph_rdy | input | 1 | Ready from the addressed peripheral |
| bus_rdy | output | 1 | High in the clock that completes the cycle |
| bus_wait | output | 1 | High in each wait clock of a cycle |

## Verification
The bench sweeps every code from 0 to 7 across all eight spaces and counts wait clocks. An off-by-one counter would show up here as one wait too many or too few, and so would a mix-up between the start clock and the first wait. It writes all ones to a register and expects the dead bits to stay clear; a design that stored full nibbles would read back 0xF in place of 0x7. It rewrites a register in the middle of a 7-wait cycle. A design that read the code live instead of capturing it would shorten that cycle. A second instance with only five implemented codes checks that the missing spaces read zero and finish at once, rather than keeping the reset value of 3.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

   // area type carried with each bus cycle start
   typedef enum logic [1:0] {
      AREA_EXT  = 2'b00,
      AREA_IROM = 2'b01,
      AREA_IRAM = 2'b10,
      AREA_PERI = 2'b11
   } area_e;

   // cycle sequencer state
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_EXT  = 2'b01,
      ST_PERI = 2'b10
   } cyc_st_e;

endpackage

// File: rtl/cs_wait_regs.sv
module cs_wait_regs #(
   parameter int NUM_CS      = 8,
   parameter int FIELD_W     = 3,
   parameter int IMPL_FIELDS = 8,
   parameter int DATA_W      = 16,
   parameter int RST_CODE    = 3,
   parameter int SEL_W       = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            sel,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [NUM_CS*FIELD_W-1:0]   fields
);

   localparam int SLOT_W = FIELD_W + 1;
   localparam int SPR    = DATA_W / SLOT_W;

   genvar f;
   generate
      for (f = 0; f < NUM_CS; f++) begin : g_field
         if (f < IMPL_FIELDS) begin : g_live
            logic [FIELD_W-1:0] code_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  code_q <= FIELD_W'(RST_CODE);
               else if (wr_en && (sel == SEL_W'(f / SPR)))
                  code_q <= wdata[(f % SPR)*SLOT_W +: FIELD_W];
            end
            assign fields[f*FIELD_W +: FIELD_W] = code_q;
         end else begin : g_dead
            assign fields[f*FIELD_W +: FIELD_W] = '0;
         end
      end
   endgenerate

   // read mux: pad bits stay zero
   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CS; k++) begin
         if (sel == SEL_W'(k / SPR))
            rdata[(k % SPR)*SLOT_W +: FIELD_W] = fields[k*FIELD_W +: FIELD_W];
      end
   end

endmodule

// File: rtl/cs_wait_sel.sv
module cs_wait_sel #(
   parameter int NUM_CS  = 8,
   parameter int FIELD_W = 3,
   parameter int CS_W    = 3
) (
   input  logic [NUM_CS*FIELD_W-1:0] fields,
   input  logic [CS_W-1:0]           cs,
   output logic [FIELD_W-1:0]        code
);

   always_comb begin
      code = '0;
      for (int k = 0; k < NUM_CS; k++) begin
         if (cs == CS_W'(k))
            code = fields[k*FIELD_W +: FIELD_W];
      end
   end

endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr
   import cs_wait_pkg::*;
#(
   parameter int FIELD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  area_e              area,
   input  logic [FIELD_W-1:0] code,
   input  logic               periph_rdy,
   output logic               rdy,
   output logic               wait_o
);

   cyc_st_e            st_q;
   logic [FIELD_W-1:0] cnt_q;

   always_comb begin
      rdy    = 1'b0;
      wait_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               unique case (area)
                  AREA_EXT:  rdy = (code == '0);
                  AREA_PERI: rdy = periph_rdy;
                  default:   rdy = 1'b1;
               endcase
               wait_o = !rdy;
            end
         end
         ST_EXT: begin
            rdy    = (cnt_q == '0);
            wait_o = !rdy;
         end
         ST_PERI: begin
            rdy    = periph_rdy;
            wait_o = !rdy;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start && !rdy) begin
                  if (area == AREA_PERI) begin
                     st_q <= ST_PERI;
                  end else begin
                     st_q  <= ST_EXT;
                     cnt_q <= code - FIELD_W'(1);
                  end
               end
            end
            ST_EXT: begin
               if (cnt_q == '0) st_q <= ST_IDLE;
               else             cnt_q <= cnt_q - FIELD_W'(1);
            end
            ST_PERI: begin
               if (periph_rdy) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
   import cs_wait_pkg::*;
#(
   parameter int NUM_CS      = 8,
   parameter int FIELD_W     = 3,
   parameter int IMPL_FIELDS = 8,
   parameter int DATA_W      = 16,
   parameter int RST_CODE    = 3,
   localparam int SLOT_W     = FIELD_W + 1,
   localparam int NUM_REGS   = NUM_CS / (DATA_W / SLOT_W),
   localparam int SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cyc_start,
   input  logic [1:0]        cyc_area,
   input  logic [CS_W-1:0]   cyc_cs,
   input  logic              periph_rdy,
   output logic              bus_rdy,
   output logic              bus_wait
);

   // elaboration-time parameter checks
   generate
      if (FIELD_W < 1) begin : g_bad_fw
         $error("FIELD_W must be at least 1");
      end
      if (DATA_W % SLOT_W != 0) begin : g_bad_dw
         $error("DATA_W must be a multiple of FIELD_W+1");
      end
      if (NUM_CS % (DATA_W / SLOT_W) != 0) begin : g_bad_cs
         $error("NUM_CS must fill whole registers");
      end
      if (IMPL_FIELDS > NUM_CS) begin : g_bad_impl
         $error("IMPL_FIELDS exceeds NUM_CS");
      end
      if (RST_CODE >= (1 << FIELD_W)) begin : g_bad_rst
         $error("RST_CODE does not fit FIELD_W");
      end
   endgenerate

   logic [NUM_CS*FIELD_W-1:0] fields;
   logic [FIELD_W-1:0]        code;

   cs_wait_regs #(
      .NUM_CS(NUM_CS), .FIELD_W(FIELD_W), .IMPL_FIELDS(IMPL_FIELDS),
      .DATA_W(DATA_W), .RST_CODE(RST_CODE), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
      .wdata(reg_wdata), .rdata(reg_rdata), .fields(fields)
   );

   cs_wait_sel #(
      .NUM_CS(NUM_CS), .FIELD_W(FIELD_W), .CS_W(CS_W)
   ) u_sel (
      .fields(fields), .cs(cyc_cs), .code(code)
   );

   cs_wait_ctr #(
      .FIELD_W(FIELD_W)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(cyc_start),
      .area(area_e'(cyc_area)), .code(code), .periph_rdy(periph_rdy),
      .rdy(bus_rdy), .wait_o(bus_wait)
   );

endmodule

// File: rtl/cs_wait_chk.sv
module cs_wait_chk #(
   parameter int NUM_CS      = 8,
   parameter int FIELD_W     = 3,
   parameter int IMPL_FIELDS = 8,
   parameter int DATA_W      = 16,
   parameter int SEL_W       = 1,
   parameter int CS_W        = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  reg_sel,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              cyc_start,
   input logic [1:0]        cyc_area,
   input logic              periph_rdy,
   input logic              bus_rdy,
   input logic              bus_wait
);

   localparam int SLOT_W   = FIELD_W + 1;
   localparam int SPR      = DATA_W / SLOT_W;
   localparam int MAX_WAIT = (1 << FIELD_W) - 1;

   logic              in_q;
   logic [1:0]        area_q;
   logic [FIELD_W:0]  wcnt_q;
   logic [DATA_W-1:0] live_mask;
   logic [1:0]        area_now;

   always_comb begin
      live_mask = '0;
      for (int k = 0; k < IMPL_FIELDS; k++) begin
         if (reg_sel == SEL_W'(k / SPR))
            live_mask[(k % SPR)*SLOT_W +: FIELD_W] = '1;
      end
   end

   assign area_now = in_q ? area_q : cyc_area;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= 1'b0;
         area_q <= 2'b00;
         wcnt_q <= '0;
      end else begin
         if (bus_rdy) in_q <= 1'b0;
         else if (cyc_start && !in_q) begin
            in_q   <= 1'b1;
            area_q <= cyc_area;
         end
         if (bus_rdy || (!in_q && !cyc_start)) wcnt_q <= '0;
         else if (bus_wait)                     wcnt_q <= wcnt_q + 1'b1;
      end
   end

   // R3, R8
   dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~live_mask) == '0);

   // R4
   ext_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wait && area_now == 2'b00) |-> (wcnt_q < (FIELD_W+1)'(MAX_WAIT)));

   // R5
   int_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !in_q && (cyc_area == 2'b01 || cyc_area == 2'b10)) |-> (bus_rdy && !bus_wait));

   // R6
   periph_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_start || in_q) && area_now == 2'b11) |-> (bus_rdy == periph_rdy));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_q && !cyc_start) |-> (!bus_rdy && !bus_wait));

   // R4
   rdy_wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdy |=> (!bus_wait || cyc_start));

endmodule

bind cs_wait_gen cs_wait_chk #(
   .NUM_CS(NUM_CS), .FIELD_W(FIELD_W), .IMPL_FIELDS(IMPL_FIELDS),
   .DATA_W(DATA_W), .SEL_W(SEL_W), .CS_W(CS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
   .cyc_start(cyc_start), .cyc_area(cyc_area), .periph_rdy(periph_rdy),
   .bus_rdy(bus_rdy), .bus_wait(bus_wait)
);

// File: tb/cs_wait_gen_bench.sv
module cs_wait_gen_bench;

   localparam int CLK_P = 10;
   localparam int NVEC  = 13;

   // {area[1:0], cs[2:0], periph_delay[3:0], expected_waits[3:0]}
   localparam logic [12:0] VEC [NVEC] = '{
      {2'b00, 3'd0, 4'd0, 4'd0},
      {2'b00, 3'd1, 4'd0, 4'd1},
      {2'b00, 3'd2, 4'd0, 4'd2},
      {2'b00, 3'd3, 4'd0, 4'd7},
      {2'b00, 3'd4, 4'd0, 4'd3},
      {2'b00, 3'd5, 4'd0, 4'd4},
      {2'b00, 3'd6, 4'd0, 4'd5},
      {2'b00, 3'd7, 4'd0, 4'd6},
      {2'b01, 3'd3, 4'd0, 4'd0},
      {2'b10, 3'd7, 4'd0, 4'd0},
      {2'b11, 3'd3, 4'd2, 4'd2},
      {2'b11, 3'd0, 4'd0, 4'd0},
      {2'b11, 3'd7, 4'd5, 4'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [0:0]  reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata, part_rdata;
   logic        cyc_start = 1'b0;
   logic [1:0]  cyc_area = 2'b00;
   logic [2:0]  cyc_cs = '0;
   logic        periph_rdy = 1'b0;
   logic        bus_rdy, bus_wait, part_rdy, part_wait;

   int checks = 0;
   int errors = 0;
   int waits;
   logic part_first_rdy;

   always #(CLK_P/2) clk = ~clk;

   cs_wait_gen u_cs_wait_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_start(cyc_start),
      .cyc_area(cyc_area), .cyc_cs(cyc_cs), .periph_rdy(periph_rdy),
      .bus_rdy(bus_rdy), .bus_wait(bus_wait)
   );

   cs_wait_gen #(.IMPL_FIELDS(5)) u_cs_wait_gen_part (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(part_rdata), .cyc_start(cyc_start),
      .cyc_area(cyc_area), .cyc_cs(cyc_cs), .periph_rdy(periph_rdy),
      .bus_rdy(part_rdy), .bus_wait(part_wait)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   task automatic write_reg(input logic s, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic s, input int exp);
      @(negedge clk);
      reg_sel = s; #1;
      chk(tag, int'(reg_rdata), exp);
   endtask

   // runs one bus cycle, counts wait clocks until bus_rdy
   task automatic run_cycle(input logic [1:0] area, input logic [2:0] cs,
                            input int pd, input logic do_wr,
                            input logic [15:0] wd, output int nw);
      bit done = 0;
      nw = 0;
      @(negedge clk);
      cyc_start = 1'b1; cyc_area = area; cyc_cs = cs;
      if (do_wr) begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = wd; end
      for (int n = 0; n < 40 && !done; n++) begin
         periph_rdy = (nw >= pd);
         #1;
         if (n == 0) part_first_rdy = part_rdy;
         if (bus_rdy) done = 1;
         else nw++;
         @(posedge clk); #1;
         cyc_start = 1'b0; reg_wr = 1'b0;
         if (!done) @(negedge clk);
      end
      periph_rdy = 1'b0;
      if (!done) nw = -1;
   endtask

   initial begin
      #(CLK_P*200000);
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P*3);
      @(negedge clk); #1;
      // R9: idle outputs low during and after reset
      chk("R9 idle rdy", int'(bus_rdy), 0);
      chk("R9 idle wait", int'(bus_wait), 0);
      rst_n = 1'b1;

      // R1 reset values
      read_chk("R1 reg0 reset", 1'b0, 16'h3333);
      read_chk("R1 reg1 reset", 1'b1, 16'h3333);
      // R8 unimplemented fields read zero
      reg_sel = 1'b1; #1;
      chk("R8 part reg1 reset", int'(part_rdata), 16'h0003);
      run_cycle(2'b00, 3'd6, 0, 1'b0, 16'h0, waits);
      chk("R1 cs6 default waits", waits, 3);
      chk("R8 part cs6 zero wait", int'(part_first_rdy), 1);

      // R3 pad bits discarded; R10 other register untouched
      write_reg(1'b1, 16'hFFFF);
      read_chk("R3 reg1 pads", 1'b1, 16'h7777);
      read_chk("R10 reg0 unchanged", 1'b0, 16'h3333);

      // R2 field layout
      write_reg(1'b0, 16'h7210);
      write_reg(1'b1, 16'h6543);
      read_chk("R2 reg0", 1'b0, 16'h7210);
      read_chk("R2 reg1", 1'b1, 16'h6543);

      // vector table: R4 external, R5 internal, R6 peripheral
      for (int i = 0; i < NVEC; i++) begin
         logic [12:0] v;
         v = VEC[i];
         run_cycle(v[12:11], v[10:8], int'(v[7:4]), 1'b0, 16'h0, waits);
         if (v[12:11] == 2'b00)      chk($sformatf("R4 vec%0d", i), waits, int'(v[3:0]));
         else if (v[12:11] == 2'b11) chk($sformatf("R6 vec%0d", i), waits, int'(v[3:0]));
         else                        chk($sformatf("R5 vec%0d", i), waits, int'(v[3:0]));
         @(negedge clk); #1;
         chk($sformatf("R9 post vec%0d", i), int'(bus_rdy | bus_wait), 0);
      end

      // R7 write during a 7-wait cycle does not shorten it
      run_cycle(2'b00, 3'd3, 0, 1'b1, 16'h0000, waits);
      chk("R7 latched length", waits, 7);
      read_chk("R7 write landed", 1'b0, 16'h0000);
      run_cycle(2'b00, 3'd3, 0, 1'b0, 16'h0, waits);
      chk("R7 next cycle new code", waits, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule